// File: doc/BRIEF.md
# Polar Encoder, Length 8, Five Message Bits

This block turns a 5-bit message into an 8-bit polar codeword. The message is spread over the information positions of an 8-entry input vector, and the remaining positions are tied to zero. The vector is then passed through a three-stage XOR butterfly network. That network equals multiplication by the third Kronecker power of the 2x2 lower-triangular kernel, at N log N cost.

Which positions carry information is fixed when the block is elaborated, through a bit mask parameter. The default marks positions 1, 3, 5, 6 and 7 as information and positions 0, 2 and 4 as frozen. A second parameter can present the codeword in bit-reversed index order.

The block takes one message per clock whenever its input strobe is high. It returns the codeword from a register one cycle later, with its own strobe. It suits a transmit chain that needs a fixed short polar code at full clock rate.

Top module: `polar_encoder`

## Requirements
- R1: The block takes a 5-bit message on `in_msg` and produces an 8-bit codeword on `out_cw`.
- R2: Message bit k (k = 0 for the least significant bit) is placed on the k-th set bit of the information mask, counting from index 0 upward. The default mask 0xEA puts m[0..4] on indices 1, 3, 5, 6 and 7.
- R3: Indices that are clear in the mask (0, 2 and 4 by default) enter the transform as zero, whatever the message is.
- R4: With the output ordering parameter at 0, codeword bit j equals the XOR of the input vector bits u[i] over every i with (i AND j) == j. This is the product of the row vector u with the third Kronecker power of [[1,0],[1,1]]. Bit 0 is therefore the parity of all of u.
- R5: `out_valid` is high in exactly the cycles that follow a clock edge at which `in_valid` was high. A message presented on every cycle yields a codeword on every cycle.
- R6: After a clock edge at which `in_valid` is low, `out_cw` keeps its previous value, whatever `in_msg` carries.
- R7: A synchronous active-high `rst` clears `out_valid` and `out_cw` to zero at the next clock edge, and it takes priority over an accepted message.
- R8: With the output ordering parameter at 1, output bit j carries the R4 codeword bit at the index whose 3-bit binary form is j reversed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Message present this cycle |
| in_msg | input | 5 | Message bits |
| out_valid | output | 1 | Codeword valid, one cycle after acceptance |
| out_cw | output | 8 | Registered codeword |

## Verification
Two things can happen at the same clock edge: the block hands out the previous codeword while it captures a new message. The bench provokes this by presenting all 32 messages on consecutive cycles with the strobe held high. It judges each cycle's output against a codeword that it computes itself, by masked placement followed by the subset-XOR product. Reset is also asserted in the same cycle as an accepted message, and the registers must come out cleared instead of loaded.

// File: rtl/polar_enc_pkg.sv
`timescale 1ns/1ps
package polar_enc_pkg;

  // Widest mask the helper functions handle.
  localparam int MAX_N = 64;

  // Number of set mask bits below position pos.
  function automatic int info_rank(input logic [MAX_N-1:0] mask, input int pos);
    int r;
    r = 0;
    for (int i = 0; i < MAX_N; i++) begin
      if (i < pos && mask[i]) r++;
    end
    return r;
  endfunction

  // Reverse the lowest nbits of idx.
  function automatic int bit_rev(input int idx, input int nbits);
    int r;
    r = 0;
    for (int b = 0; b < 32; b++) begin
      if (b < nbits && ((idx >> b) & 1) == 1) r = r | (1 << (nbits - 1 - b));
    end
    return r;
  endfunction

endpackage

// File: rtl/polar_frozen_map.sv
`timescale 1ns/1ps
module polar_frozen_map
  import polar_enc_pkg::*;
#(
  parameter int N = 8,
  parameter int K = 5,
  parameter logic [N-1:0] INFO_MASK = 8'hEA
) (
  input  logic [K-1:0] msg,
  output logic [N-1:0] u
);

  // Each vector slot is either fed by a message bit or tied to zero.
  for (genvar i = 0; i < N; i++) begin : g_slot
    localparam int RANK = info_rank(MAX_N'(INFO_MASK), i);
    if (INFO_MASK[i] && RANK < K) begin : g_info
      assign u[i] = msg[RANK];
    end else begin : g_frozen
      assign u[i] = 1'b0;
    end
  end

  // R2/R3: the placement is a permutation of the message into the vector.
  always_comb begin
    a_r2_weight_kept: assert ($countones(u) == $countones(msg));
  end

endmodule

// File: rtl/polar_butterfly.sv
`timescale 1ns/1ps
module polar_butterfly #(
  parameter int N_LOG = 3,
  localparam int N = 1 << N_LOG
) (
  input  logic [N-1:0] u,
  output logic [N-1:0] x
);

  // st[s] is the vector entering stage s.
  logic [N_LOG:0][N-1:0] st;

  assign st[0] = u;

  for (genvar s = 0; s < N_LOG; s++) begin : g_stage
    for (genvar i = 0; i < N; i++) begin : g_node
      if (((i >> s) & 1) == 0) begin : g_upper
        assign st[s+1][i] = st[s][i] ^ st[s][i + (1 << s)];
      end else begin : g_lower
        assign st[s+1][i] = st[s][i];
      end
    end
  end

  assign x = st[N_LOG];

  // R4: the first output is the parity of the whole vector, and the last passes straight through.
  always_comb begin
    a_r4_parity_head: assert (x[0] == ^u);
    a_r4_tail_pass: assert (x[N-1] == u[N-1]);
  end

endmodule

// File: rtl/polar_encoder.sv
`timescale 1ns/1ps
module polar_encoder
  import polar_enc_pkg::*;
#(
  parameter int N_LOG = 3,
  localparam int N = 1 << N_LOG,
  parameter int K = 5,
  parameter logic [N-1:0] INFO_MASK = 8'hEA,
  parameter bit OUT_BITREV = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [K-1:0] in_msg,
  output logic         out_valid,
  output logic [N-1:0] out_cw
);

  logic [N-1:0] u_vec;
  logic [N-1:0] x_nat;
  logic [N-1:0] cw_ord;

  polar_frozen_map #(
    .N(N),
    .K(K),
    .INFO_MASK(INFO_MASK)
  ) u_map (
    .msg(in_msg),
    .u(u_vec)
  );

  polar_butterfly #(
    .N_LOG(N_LOG)
  ) u_bfly (
    .u(u_vec),
    .x(x_nat)
  );

  // Output index order: natural, or bit-reversed (R8).
  if (OUT_BITREV) begin : g_rev
    for (genvar j = 0; j < N; j++) begin : g_bit
      assign cw_ord[j] = x_nat[bit_rev(j, N_LOG)];
    end
  end else begin : g_nat
    assign cw_ord = x_nat;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_cw    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_cw <= cw_ord;
    end
  end

  // R5: the output strobe follows an accepted message one cycle later.
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R5: no output strobe without an accepted message.
  a_r5_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R6: the codeword holds while nothing is accepted.
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_cw));

endmodule

// File: tb/tb_polar_encoder.sv
`timescale 1ns/1ps
module tb_polar_encoder;

  localparam int N_LOG = 3;
  localparam int N = 8;
  localparam int K = 5;
  localparam logic [N-1:0] MASK = 8'hEA;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [K-1:0] in_msg = '0;
  logic         out_valid;
  logic [N-1:0] out_cw;
  logic         rv_valid;
  logic [N-1:0] rv_cw;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  polar_encoder #(.N_LOG(N_LOG), .K(K), .INFO_MASK(MASK), .OUT_BITREV(1'b0)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(out_valid), .out_cw(out_cw)
  );

  polar_encoder #(.N_LOG(N_LOG), .K(K), .INFO_MASK(MASK), .OUT_BITREV(1'b1)) dut_rev (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_msg(in_msg),
    .out_valid(rv_valid), .out_cw(rv_cw)
  );

  // Reference: masked placement, then the subset-XOR matrix product.
  function automatic logic [N-1:0] ref_cw(input logic [K-1:0] m);
    logic [N-1:0] u;
    logic [N-1:0] x;
    int k;
    k = 0;
    for (int i = 0; i < N; i++) begin
      if (MASK[i]) begin
        u[i] = m[k];
        k++;
      end else begin
        u[i] = 1'b0;
      end
    end
    for (int j = 0; j < N; j++) begin
      x[j] = 1'b0;
      for (int i = 0; i < N; i++) begin
        if ((i & j) == j) x[j] = x[j] ^ u[i];
      end
    end
    return x;
  endfunction

  function automatic logic [N-1:0] ref_rev(input logic [N-1:0] x);
    logic [N-1:0] y;
    for (int j = 0; j < N; j++) begin
      y[j] = x[{j[0], j[1], j[2]}];
    end
    return y;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    logic [N-1:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R7: reset state
    chk(out_valid == 1'b0, "R7 reset valid", {7'd0, out_valid}, 8'd0);
    chk(out_cw == 8'd0, "R7 reset codeword", out_cw, 8'd0);
    chk(rv_valid == 1'b0 && rv_cw == 8'd0, "R7 reset bitrev instance", rv_cw, 8'd0);
    rst = 1'b0;

    // R1 R2 R3 R4 R5 R8: all messages back to back
    in_valid = 1'b1;
    in_msg = 5'd0;
    for (int m = 0; m < 32; m++) begin
      @(negedge clk);
      e = ref_cw(m[K-1:0]);
      chk(out_valid == 1'b1, "R5 back-to-back valid", {7'd0, out_valid}, 8'd1);
      chk(out_cw == e, "R1 R2 R3 R4 codeword", out_cw, e);
      chk(rv_cw == ref_rev(e), "R8 bit-reversed codeword", rv_cw, ref_rev(e));
      if (m < 31) begin
        in_msg = 5'(m + 1);
      end else begin
        in_valid = 1'b0;
        in_msg = 5'h15;
      end
    end

    // R6: hold while idle, with the message input changing
    e = ref_cw(5'd31);
    for (int c = 0; c < 2; c++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R5 idle valid low", {7'd0, out_valid}, 8'd0);
      chk(out_cw == e, "R6 codeword held", out_cw, e);
      in_msg = 5'h0C;
    end

    // R5: a single strobe gives a single-cycle output strobe
    in_valid = 1'b1;
    in_msg = 5'h0A;
    @(negedge clk);
    in_valid = 1'b0;
    in_msg = 5'h13;
    e = ref_cw(5'h0A);
    chk(out_valid == 1'b1, "R5 single strobe", {7'd0, out_valid}, 8'd1);
    chk(out_cw == e, "R4 single message", out_cw, e);
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 strobe ends", {7'd0, out_valid}, 8'd0);
    chk(out_cw == e, "R6 held after single", out_cw, e);

    // R7: reset wins over an accepted message in the same cycle
    in_valid = 1'b1;
    in_msg = 5'h1F;
    rst = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R7 reset over capture valid", {7'd0, out_valid}, 8'd0);
    chk(out_cw == 8'd0, "R7 reset over capture codeword", out_cw, 8'd0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R5 no strobe after reset", {7'd0, out_valid}, 8'd0);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

endmodule